// File: doc/BRIEF.md
# Machine Check Exception Controller

This controller gathers hardware error reports inside a processor core and decides when the core enters its machine-check handler. There are two kinds of report. A synchronous flag is tied to the instruction that is being fetched or executed now. Asynchronous strobes come from the instruction cache, the instruction read port, the data read and write ports, the data cache and the translation buffer.

Asynchronous reports are sticky. They set a summary bit and a cause bit in a status register, and they wait there until the enable bit allows the interrupt. A synchronous report is different. It is acted on in the same cycle or not at all: with the enable bit clear it is dropped for good, and only the syndrome bit remembers that it happened.

When the interrupt is taken, the controller does four things. It pulses `take_irq` and forms the handler address from a prefix field and an offset field. It saves a return address and clears the enable bit. An interrupt-return strobe later restores the enable bit from the copy saved at entry. Software clears status bits through a write-one-to-clear port.

Top module: `mchk_ctrl`

## Requirements
- R1: After reset, `mc_status`, `syndrome`, `save_pc` and `mc_en` are all zero, so `take_irq` and `suppress` are low.
- R2: When `ifetch_mc` is high and `mc_en` is 1, `take_irq` and `suppress` are high in that same cycle. After the edge, `save_pc` holds that cycle's `cur_pc`.
- R3: When `ifetch_mc` is high and `mc_en` is 0, neither `take_irq` nor `suppress` rises, and no interrupt follows later even once `mc_en` is set. `syndrome` is set after the edge whatever `mc_en` is.
- R4: Each asynchronous cause sets its own `mc_status` bit after the edge, and also sets the summary bit 0. The cause bits are:
  - bit 1: `icache_par` or `iread_irq`
  - bit 2: `drd_busy` together with any of `drd_tmo`, `drd_err`, `drd_irq`
  - bit 3: `dwr_busy` together with any of `dwr_tmo`, `dwr_err`, `dwr_irq`
  - bit 4: `dcache_par`
  - bit 5: `tlb_par`

  A read or write error strobe with its busy line low has no effect.
- R5: `take_irq` is high in every cycle in which `mc_status[0]` and `mc_en` are both 1. A pending asynchronous error therefore waits while `mc_en` is 0 and is taken in the first cycle `mc_en` reads 1. With no synchronous flag in the taking cycle, `save_pc` gets that cycle's `next_pc`.
- R6: `vector` always equals `{vec_pfx, vec_ofs, 4'b0000}`.
- R7: In the cycle after `take_irq`, `mc_en` reads 0. A `mc_return` pulse sets `mc_en` to the value `mc_en` had when the interrupt was taken.
- R8: While `clr_valid` is high, each 1 in `clr_mask[5:0]` clears the matching `mc_status` bit, and `clr_mask[6]` clears `syndrome`. An event in the same cycle wins over the clear. If the summary bit is still set when `mc_return` re-enables, the interrupt is taken again.
- R9: Synchronous and asynchronous events in one cycle cause a single interrupt. Status and syndrome are both updated, and `save_pc` takes `cur_pc`.
- R10: `save_pc` changes only on a cycle with `take_irq` high.
- R11: Updates to `mc_en` have a fixed priority: taking the interrupt (clears) wins over `mc_return` (restores), which wins over a software write (`en_wr` with `en_wdata`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ifetch_mc | input | 1 | Synchronous machine check on the current instruction |
| icache_par | input | 1 | Instruction cache parity error |
| iread_irq | input | 1 | Interrupt request from the instruction read port |
| drd_busy | input | 1 | A data read is in progress |
| drd_tmo | input | 1 | Data read timeout |
| drd_err | input | 1 | Data read error |
| drd_irq | input | 1 | Data read interrupt request |
| dwr_busy | input | 1 | A data write is in progress |
| dwr_tmo | input | 1 | Data write timeout |
| dwr_err | input | 1 | Data write error |
| dwr_irq | input | 1 | Data write interrupt request |
| dcache_par | input | 1 | Data cache parity error |
| tlb_par | input | 1 | Translation buffer parity error |
| en_wr | input | 1 | Software write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| mc_return | input | 1 | Return from the machine-check handler |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 7 | Bits to clear: [5:0] status, [6] syndrome |
| cur_pc | input | AW | Address of the current instruction |
| next_pc | input | AW | Address of the next instruction to execute |
| vec_pfx | input | AW-OW-4 | Upper field of the handler address |
| vec_ofs | input | OW | Machine-check offset field |
| take_irq | output | 1 | The interrupt is taken in this cycle |
| vector | output | AW | Handler address |
| save_pc | output | AW | Saved return address |
| mc_status | output | 6 | Status: [0] summary, [5:1] causes |
| syndrome | output | 1 | A synchronous machine check was seen |
| mc_en | output | 1 | Machine-check enable bit |
| suppress | output | 1 | Suppress the current instruction |

## Verification
The bench builds the controller with AW=16 and OW=6, which gives a 6-bit prefix and a 6-bit offset. With fields that short, a slip at either concatenation boundary of `vector` shows up in a hand-checked 16-bit value. The same width keeps the per-step return addresses distinct, so a swap between `cur_pc` and `next_pc`, or a stale `save_pc`, changes the compared value. The vector table runs a single long sequence in which the enable bit, the saved enable copy and the sticky status carry from one step to the next. This brings the deferred-then-taken path, the refire after an early return, and the ordering of same-cycle clears, returns and writes within reach of one pass.

// File: rtl/mchk_ctrl.sv
module mchk_ctrl #(
  parameter int AW = 32,
  parameter int OW = 12,
  localparam int PW = AW - OW - 4,
  localparam int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ifetch_mc,
  input  logic          icache_par,
  input  logic          iread_irq,
  input  logic          drd_busy,
  input  logic          drd_tmo,
  input  logic          drd_err,
  input  logic          drd_irq,
  input  logic          dwr_busy,
  input  logic          dwr_tmo,
  input  logic          dwr_err,
  input  logic          dwr_irq,
  input  logic          dcache_par,
  input  logic          tlb_par,
  input  logic          en_wr,
  input  logic          en_wdata,
  input  logic          mc_return,
  input  logic          clr_valid,
  input  logic [SW:0]   clr_mask,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] next_pc,
  input  logic [PW-1:0] vec_pfx,
  input  logic [OW-1:0] vec_ofs,
  output logic          take_irq,
  output logic [AW-1:0] vector,
  output logic [AW-1:0] save_pc,
  output logic [SW-1:0] mc_status,
  output logic          syndrome,
  output logic          mc_en,
  output logic          suppress
);

  logic [SW-1:0] st_q;
  logic          syn_q, en_q, en_sv_q;
  logic [AW-1:0] spc_q;

  logic          c_ifetch, c_drd, c_dwr;
  logic [SW-2:0] cause;
  logic [SW-1:0] st_set, st_clr;
  logic          syn_clr;

  assign c_ifetch = icache_par | iread_irq;
  assign c_drd    = drd_busy & (drd_tmo | drd_err | drd_irq);
  assign c_dwr    = dwr_busy & (dwr_tmo | dwr_err | dwr_irq);
  assign cause    = {tlb_par, dcache_par, c_dwr, c_drd, c_ifetch};
  assign st_set   = {cause, |cause};
  assign st_clr   = clr_valid ? clr_mask[SW-1:0] : '0;
  assign syn_clr  = clr_valid & clr_mask[SW];

  assign take_irq = en_q & (ifetch_mc | st_q[0]);
  assign suppress = en_q & ifetch_mc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      syn_q   <= 1'b0;
      en_q    <= 1'b0;
      en_sv_q <= 1'b0;
      spc_q   <= '0;
    end else begin
      st_q  <= (st_q & ~st_clr) | st_set;
      syn_q <= (syn_q & ~syn_clr) | ifetch_mc;
      if (take_irq) begin
        en_q    <= 1'b0;
        en_sv_q <= en_q;
        spc_q   <= ifetch_mc ? cur_pc : next_pc;
      end else if (mc_return) begin
        en_q <= en_sv_q;
      end else if (en_wr) begin
        en_q <= en_wdata;
      end
    end
  end

  assign vector    = {vec_pfx, vec_ofs, 4'b0000};
  assign save_pc   = spc_q;
  assign mc_status = st_q;
  assign syndrome  = syn_q;
  assign mc_en     = en_q;

endmodule

module mchk_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ifetch_mc,
  input logic          icache_par,
  input logic          dcache_par,
  input logic          tlb_par,
  input logic          en_wr,
  input logic          en_wdata,
  input logic          mc_return,
  input logic [AW-1:0] cur_pc,
  input logic [AW-1:0] next_pc,
  input logic          take_irq,
  input logic [AW-1:0] save_pc,
  input logic [5:0]    mc_status,
  input logic          syndrome,
  input logic          mc_en
);

  // R7
  take_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !mc_en);

  // R3
  syndrome_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch_mc |=> syndrome);

  // R4
  summary_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (icache_par || dcache_par || tlb_par) |=> mc_status[0]);

  // R2
  sync_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && ifetch_mc) |=> save_pc == $past(cur_pc));

  // R5
  async_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !ifetch_mc) |=> save_pc == $past(next_pc));

  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |=> $stable(save_pc));

  // R11
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !mc_return && !take_irq) |=> mc_en == $past(en_wdata));

endmodule

bind mchk_ctrl mchk_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ifetch_mc(ifetch_mc), .icache_par(icache_par),
  .dcache_par(dcache_par), .tlb_par(tlb_par), .en_wr(en_wr), .en_wdata(en_wdata),
  .mc_return(mc_return), .cur_pc(cur_pc), .next_pc(next_pc), .take_irq(take_irq),
  .save_pc(save_pc), .mc_status(mc_status), .syndrome(syndrome), .mc_en(mc_en)
);

// File: tb/tb_mchk_ctrl.sv
`timescale 1ns/1ps
module tb_mchk_ctrl;
  localparam int AW = 16;
  localparam int OW = 6;
  localparam int PW = AW - OW - 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ifetch_mc, icache_par, iread_irq, drd_busy, drd_tmo, drd_err, drd_irq;
  logic dwr_busy, dwr_tmo, dwr_err, dwr_irq, dcache_par, tlb_par;
  logic en_wr, en_wdata, mc_return, clr_valid;
  logic [6:0] clr_mask;
  logic [AW-1:0] cur_pc, next_pc, vector, save_pc;
  logic [PW-1:0] vec_pfx;
  logic [OW-1:0] vec_ofs;
  logic take_irq, syndrome, mc_en, suppress;
  logic [5:0] mc_status;

  int checks = 0, errs = 0;

  always #2 clk = ~clk;

  mchk_ctrl #(.AW(AW), .OW(OW)) dut (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        sync;
    logic [11:0] asy;
    logic [1:0]  en;
    logic        ret;
    logic [6:0]  clr;
    logic        take;
    logic        supp;
    logic [5:0]  st;
    logic        syn;
    logic        me;
  } vec_t;

  // asy bits: 0 icache_par, 1 iread_irq, 2 drd_busy, 3 drd_tmo, 4 drd_err, 5 drd_irq,
  // 6 dwr_busy, 7 dwr_tmo, 8 dwr_err, 9 dwr_irq, 10 dcache_par, 11 tlb_par
  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{4'd7,  1'b0, 12'h000, 2'b11, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1}, // R7 enable
    '{4'd2,  1'b1, 12'h000, 2'b00, 1'b0, 7'h00, 1'b1, 1'b1, 6'h00, 1'b1, 1'b0}, // R2
    '{4'd7,  1'b0, 12'h000, 2'b00, 1'b1, 7'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b1}, // R7 return
    '{4'd8,  1'b0, 12'h000, 2'b10, 1'b0, 7'h40, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0}, // R8
    '{4'd3,  1'b1, 12'h000, 2'b00, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b0}, // R3
    '{4'd3,  1'b0, 12'h000, 2'b11, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b1}, // R3
    '{4'd3,  1'b0, 12'h000, 2'b00, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00, 1'b1, 1'b1}, // R3
    '{4'd8,  1'b0, 12'h000, 2'b10, 1'b0, 7'h40, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0}, // R8
    '{4'd4,  1'b0, 12'h001, 2'b00, 1'b0, 7'h00, 1'b0, 1'b0, 6'h03, 1'b0, 1'b0}, // R4
    '{4'd4,  1'b0, 12'h008, 2'b00, 1'b0, 7'h00, 1'b0, 1'b0, 6'h03, 1'b0, 1'b0}, // R4
    '{4'd4,  1'b0, 12'h014, 2'b00, 1'b0, 7'h00, 1'b0, 1'b0, 6'h07, 1'b0, 1'b0}, // R4
    '{4'd5,  1'b0, 12'h000, 2'b11, 1'b0, 7'h00, 1'b0, 1'b0, 6'h07, 1'b0, 1'b1}, // R5
    '{4'd5,  1'b0, 12'h000, 2'b00, 1'b0, 7'h00, 1'b1, 1'b0, 6'h07, 1'b0, 1'b0}, // R5
    '{4'd7,  1'b0, 12'h000, 2'b00, 1'b1, 7'h00, 1'b0, 1'b0, 6'h07, 1'b0, 1'b1}, // R7
    '{4'd8,  1'b0, 12'h000, 2'b00, 1'b0, 7'h00, 1'b1, 1'b0, 6'h07, 1'b0, 1'b0}, // R8
    '{4'd8,  1'b0, 12'h000, 2'b00, 1'b1, 7'h3F, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1}, // R8
    '{4'd8,  1'b0, 12'h000, 2'b00, 1'b0, 7'h00, 1'b0, 1'b0, 6'h00, 1'b0, 1'b1}, // R8
    '{4'd9,  1'b1, 12'hA40, 2'b00, 1'b0, 7'h00, 1'b1, 1'b1, 6'h29, 1'b1, 1'b0}, // R9
    '{4'd8,  1'b0, 12'h0C0, 2'b00, 1'b0, 7'h29, 1'b0, 1'b0, 6'h09, 1'b1, 1'b0}, // R8
    '{4'd11, 1'b0, 12'h402, 2'b10, 1'b1, 7'h00, 1'b0, 1'b0, 6'h1B, 1'b1, 1'b1}, // R11
    '{4'd11, 1'b0, 12'h000, 2'b11, 1'b1, 7'h00, 1'b1, 1'b0, 6'h1B, 1'b1, 1'b0}  // R11
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic idle();
    {ifetch_mc, en_wr, en_wdata, mc_return, clr_valid} = '0;
    {tlb_par, dcache_par, dwr_irq, dwr_err, dwr_tmo, dwr_busy,
     drd_irq, drd_err, drd_tmo, drd_busy, iread_irq, icache_par} = '0;
    clr_mask = '0;
  endtask

  task automatic reset_checks();
    chk("R1 status", 32'(mc_status), 0);
    chk("R1 syndrome", 32'(syndrome), 0);
    chk("R1 enable", 32'(mc_en), 0);
    chk("R1 save_pc", 32'(save_pc), 0);
    chk("R1 take", 32'(take_irq), 0);
    chk("R1 suppress", 32'(suppress), 0);
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    logic [AW-1:0] exp_pc;
    idle();
    cur_pc = '0; next_pc = '0; vec_pfx = '0; vec_ofs = '0;
    repeat (3) @(posedge clk);
    #1 reset_checks();
    rst_n = 1'b1;
    exp_pc = '0;
    @(posedge clk); #1;
    for (int i = 0; i < NV; i++) begin
      vec_t v = TBL[i];
      string tag = $sformatf("R%0d step %0d", v.req, i);
      ifetch_mc = v.sync;
      {tlb_par, dcache_par, dwr_irq, dwr_err, dwr_tmo, dwr_busy,
       drd_irq, drd_err, drd_tmo, drd_busy, iread_irq, icache_par} = v.asy;
      {en_wr, en_wdata} = v.en;
      mc_return = v.ret;
      clr_valid = |v.clr;
      clr_mask = v.clr;
      cur_pc = AW'(16'h0100 + i * 8);
      next_pc = cur_pc + AW'(4);
      #1;
      chk({tag, " take"}, 32'(take_irq), 32'(v.take));
      chk({tag, " suppress"}, 32'(suppress), 32'(v.supp));
      if (v.take) exp_pc = v.sync ? cur_pc : next_pc;
      @(posedge clk); #1;
      chk({tag, " status"}, 32'(mc_status), 32'(v.st));
      chk({tag, " syndrome"}, 32'(syndrome), 32'(v.syn));
      chk({tag, " enable"}, 32'(mc_en), 32'(v.me));
      chk(v.take ? {tag, " save_pc"} : {tag, " save_pc hold R10"}, 32'(save_pc), 32'(exp_pc));
    end
    idle();
    // R6 vector formation at both field boundaries
    vec_pfx = 6'h2A; vec_ofs = 6'h15; #1;
    chk("R6 vector a", 32'(vector), 32'h0000A950);
    vec_pfx = 6'h01; vec_ofs = 6'h20; #1;
    chk("R6 vector b", 32'(vector), 32'h00000600);
    // R1 reset again from a busy state
    @(posedge clk); #1 rst_n = 1'b0;
    #1 reset_checks();
    rst_n = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule